// File: doc/BRIEF.md
# Load-Use Interlock Unit

This unit sits in the decode stage of a five-stage in-order pipeline and decides when the front of the pipe must wait. It compares the source registers of the instruction held in the IF/ID latch with the destination of the instruction held in the ID/EX latch. When that older instruction is a live load and the younger one needs its result, the value cannot reach the execute stage in time through forwarding. The unit then freezes the program counter and the IF/ID latch for one cycle and tells the ID/EX latch to take a zero no-op with its valid bit cleared.

Every other read-after-write case is left to the forwarding network. Reads happen in decode and writes happen in write-back for all instructions, so write-after-read and write-after-write ordering needs no detection here. A store that needs the loaded value only as its data operand does not wait, because that operand is forwarded to the memory input. A small internal flag records that a stall was issued in the previous cycle. This limits each load-use pair to one bubble, even when the latch inputs are left unchanged.

Instruction fields: opcode in bits 31:26, first source in bits 25:21, second field in bits 20:16. A load writes the register named in bits 20:16. The opcodes are: register-register ALU 0x00, jump 0x02, branch 0x04, immediate ALU 0x08, load 0x23, store 0x2B. Any other opcode reads no register.

Top module: `load_use_interlock`

## Requirements
- R1: When `idex_valid` is 1, `idex_instr` has opcode 0x23 and its bits 20:16 equal a nonzero value N, and `ifid_instr` has opcode 0x00, 0x04, 0x08, 0x23 or 0x2B with bits 25:21 equal to N, the unit stalls in that same cycle. A stall means `pc_write`=0, `ifid_write`=0 and `idex_bubble`=1.
- R2: With the same live load, the unit also stalls when `ifid_instr` has opcode 0x00 or 0x04 and its bits 20:16 equal N.
- R3: A store (0x2B) whose bits 20:16 equal N and whose bits 25:21 differ from N does not stall. An immediate ALU (0x08) or load (0x23) consumer whose bits 20:16 equal N also does not stall, because for these opcodes that field is a destination.
- R4: No stall is raised when the load's destination field is 0, or when the only matching consumer field is 0.
- R5: No stall is raised when `idex_valid` is 0, or when the ID/EX opcode is anything other than 0x23.
- R6: In the cycle after a stall, no stall is raised, whatever the inputs are. A stall lasts one cycle even when both consumer fields match.
- R7: When not stalling, `pc_write`=1, `ifid_write`=1 and `idex_bubble`=0. This is also the state right after reset.
- R8: A consumer whose opcode is 0x02, or any opcode not listed above, never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifid_instr | input | 32 | Instruction word in the IF/ID latch (consumer) |
| idex_instr | input | 32 | Instruction word in the ID/EX latch (possible load) |
| idex_valid | input | 1 | ID/EX latch holds a live instruction |
| pc_write | output | 1 | Program counter may advance |
| ifid_write | output | 1 | IF/ID latch may load |
| idex_bubble | output | 1 | ID/EX latch must take a zero no-op with valid cleared |

## Verification
Two functions can fall in the same cycle: hazard detection against a fresh match, and the one-bubble limit left over from the previous cycle's stall. The bench provokes the overlap by holding a matching load and consumer on the latch inputs for several consecutive cycles. It expects stall, release, stall in turn. It also applies a consumer whose two source fields both name the loaded register, and judges that the result is still a single stall cycle. Random sequences over a four-register space then make back-to-back matches frequent, and a bench model carrying its own previous-stall flag judges every cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned OP_W    = 6;
  localparam int unsigned OP_LSB  = 26;
  localparam int unsigned SA_LSB  = 21;
  localparam int unsigned SB_LSB  = 16;
  localparam int unsigned N_SRC   = 2;

  localparam logic [OP_W-1:0] OP_ALU_RR = 6'h00;
  localparam logic [OP_W-1:0] OP_JUMP   = 6'h02;
  localparam logic [OP_W-1:0] OP_BRANCH = 6'h04;
  localparam logic [OP_W-1:0] OP_ALU_IM = 6'h08;
  localparam logic [OP_W-1:0] OP_LOAD   = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE  = 6'h2B;

  typedef struct packed {
    logic             used;
    logic [REG_W-1:0] idx;
  } src_ref_t;
endpackage

// File: rtl/hz_src_decode.sv
module hz_src_decode
  import hz_pkg::*;
#(
  parameter int unsigned IW = INSTR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IW-1:0]          instr,
  output src_ref_t [N_SRC-1:0]   srcs
);
  logic [OP_W-1:0] op;
  logic            rd_a;
  logic            rd_b;
  logic            unused_low;

  assign op         = instr[OP_LSB +: OP_W];
  assign unused_low = ^instr[SB_LSB-1:0];

  always_comb begin
    rd_a = 1'b0;
    rd_b = 1'b0;
    unique case (op)
      OP_ALU_RR: begin rd_a = 1'b1; rd_b = 1'b1; end
      OP_BRANCH: begin rd_a = 1'b1; rd_b = 1'b1; end
      OP_ALU_IM: rd_a = 1'b1;
      OP_LOAD:   rd_a = 1'b1;
      OP_STORE:  rd_a = 1'b1; // data operand is forwarded to memory input
      default:   begin rd_a = 1'b0; rd_b = 1'b0; end
    endcase
  end

  assign srcs[0].used = rd_a;
  assign srcs[0].idx  = instr[SA_LSB +: REG_W];
  assign srcs[1].used = rd_b;
  assign srcs[1].idx  = instr[SB_LSB +: REG_W];

  // R3: a store never presents its data field as a stalling source
  p_store_data_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[OP_LSB +: OP_W] == OP_STORE) |-> !srcs[1].used);
  // R8: a jump reads no register
  p_jump_reads_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[OP_LSB +: OP_W] == OP_JUMP) |-> !(srcs[0].used || srcs[1].used));
endmodule

// File: rtl/hz_load_decode.sv
module hz_load_decode
  import hz_pkg::*;
#(
  parameter int unsigned IW = INSTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    instr,
  input  logic             valid,
  output logic             live_load,
  output logic [REG_W-1:0] dst
);
  logic unused_rest;

  assign unused_rest = ^{instr[SA_LSB +: REG_W], instr[SB_LSB-1:0]};
  assign dst         = instr[SB_LSB +: REG_W];
  assign live_load   = valid && (instr[OP_LSB +: OP_W] == OP_LOAD)
                       && (dst != '0);

  // R5: an empty slot never counts as a producer
  p_invalid_not_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !live_load);
endmodule

// File: rtl/hz_match.sv
module hz_match
  import hz_pkg::*;
#(
  parameter int unsigned NS = N_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_ref_t [NS-1:0] srcs,
  input  logic             live_load,
  input  logic [REG_W-1:0] dst,
  output logic             hit
);
  logic [NS-1:0] per_src;

  for (genvar g = 0; g < NS; g++) begin : g_cmp
    assign per_src[g] = live_load && srcs[g].used
                        && (srcs[g].idx == dst) && (srcs[g].idx != '0);
  end

  assign hit = |per_src;

  // R4: register zero is never a dependence
  p_zero_reg_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dst == '0) |-> !hit);
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
  import hz_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] ifid_instr,
  input  logic [INSTR_W-1:0] idex_instr,
  input  logic               idex_valid,
  output logic               pc_write,
  output logic               ifid_write,
  output logic               idex_bubble
);
  src_ref_t [N_SRC-1:0] srcs;
  logic                 live_load;
  logic [REG_W-1:0]     dst;
  logic                 hit;
  logic                 stall;
  logic                 stalled_q;
  logic                 stalled_d;

  hz_src_decode #(.IW(INSTR_W)) u_src (
    .clk(clk), .rst_n(rst_n), .instr(ifid_instr), .srcs(srcs)
  );

  hz_load_decode #(.IW(INSTR_W)) u_ld (
    .clk(clk), .rst_n(rst_n), .instr(idex_instr), .valid(idex_valid),
    .live_load(live_load), .dst(dst)
  );

  hz_match #(.NS(N_SRC)) u_cmp (
    .clk(clk), .rst_n(rst_n), .srcs(srcs), .live_load(live_load),
    .dst(dst), .hit(hit)
  );

  // one bubble per load-use pair
  assign stall = hit && !stalled_q;

  always_comb begin
    stalled_d = stall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stalled_q <= 1'b0;
    else        stalled_q <= stalled_d;
  end

  assign pc_write    = !stall;
  assign ifid_write  = !stall;
  assign idex_bubble = stall;

  // R6: never two stall cycles in a row
  p_single_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> !idex_bubble);
  // R7: hold and bubble controls move together
  p_hold_consistent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_write == ifid_write) && (pc_write != idex_bubble));
endmodule

// File: tb/load_use_interlock_tb_top.sv
module load_use_interlock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ifid_instr = '0;
  logic [31:0] idex_instr = '0;
  logic        idex_valid = 1'b0;
  logic        pc_write, ifid_write, idex_bubble;

  int checks = 0;
  int errors = 0;
  bit prev_stall = 1'b0;

  always #5 clk = ~clk;

  load_use_interlock dut_i (
    .clk(clk), .rst_n(rst_n), .ifid_instr(ifid_instr), .idex_instr(idex_instr),
    .idex_valid(idex_valid), .pc_write(pc_write), .ifid_write(ifid_write),
    .idex_bubble(idex_bubble)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
                                     input logic [4:0] b, input logic [15:0] lo);
    return {op, a, b, lo};
  endfunction

  function automatic bit hazard(input logic [31:0] c, input logic [31:0] p, input bit v);
    logic [5:0] cop, pop;
    logic [4:0] d, sa, sb;
    bit ra, rb;
    cop = c[31:26]; pop = p[31:26];
    d = p[20:16]; sa = c[25:21]; sb = c[20:16];
    ra = (cop == 6'h00) || (cop == 6'h04) || (cop == 6'h08) || (cop == 6'h23) || (cop == 6'h2B);
    rb = (cop == 6'h00) || (cop == 6'h04);
    if (!v || pop != 6'h23 || d == 5'd0) return 1'b0;
    return (ra && sa == d) || (rb && sb == d);
  endfunction

  task automatic check(input string req, input bit exp_stall);
    checks++;
    if (pc_write !== !exp_stall || ifid_write !== !exp_stall || idex_bubble !== exp_stall) begin
      errors++;
      $display("FAIL %s: pc_write=%b ifid_write=%b idex_bubble=%b expected stall=%b",
               req, pc_write, ifid_write, idex_bubble, exp_stall);
    end
  endtask

  task automatic step(input logic [31:0] c, input logic [31:0] p, input bit v,
                      input string req, input bit exp_dir, input bit use_dir);
    bit e;
    @(posedge clk); #1;
    ifid_instr = c; idex_instr = p; idex_valid = v;
    #3;
    e = hazard(c, p, v) && !prev_stall;
    if (use_dir && e != exp_dir) begin
      errors++;
      $display("FAIL %s: bench model gives %b, directed value %b", req, e, exp_dir);
    end
    check(req, e);
    prev_stall = e;
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : stim
    logic [31:0] ld3, ld0, alu3;
    logic [5:0] ops [7];
    int seed;
    ops[0] = 6'h00; ops[1] = 6'h02; ops[2] = 6'h04; ops[3] = 6'h08;
    ops[4] = 6'h23; ops[5] = 6'h2B; ops[6] = 6'h3F;
    seed = $urandom(32'd1234);
    ld3  = mk(6'h23, 5'd1, 5'd3, 16'h0010);
    ld0  = mk(6'h23, 5'd1, 5'd0, 16'h0010);
    alu3 = mk(6'h00, 5'd4, 5'd5, 16'h1800);

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #2 check("R7 reset state", 1'b0);

    step(mk(6'h00, 5'd3, 5'd5, 16'h0800), ld3, 1, "R1 rr rs1 match", 1, 1);
    step(mk(6'h00, 5'd6, 5'd5, 16'h0800), '0, 0, "R7 idle after stall", 0, 1);
    step(mk(6'h00, 5'd5, 5'd3, 16'h0800), ld3, 1, "R2 rr rs2 match", 1, 1);
    step('0, '0, 0, "R7 idle", 0, 1);
    step(mk(6'h04, 5'd7, 5'd3, 16'h0004), ld3, 1, "R2 branch second field", 1, 1);
    step('0, '0, 0, "R7 idle", 0, 1);
    step(mk(6'h2B, 5'd1, 5'd3, 16'h000C), ld3, 1, "R3 store data only", 0, 1);
    step(mk(6'h08, 5'd1, 5'd3, 16'h0001), ld3, 1, "R3 imm alu dest field", 0, 1);
    step(mk(6'h23, 5'd2, 5'd3, 16'h0001), ld3, 1, "R3 load dest field", 0, 1);
    step(mk(6'h2B, 5'd3, 5'd4, 16'h000C), ld3, 1, "R1 store base match", 1, 1);
    step('0, '0, 0, "R7 idle", 0, 1);
    step(mk(6'h00, 5'd0, 5'd0, 16'h0800), ld0, 1, "R4 load to r0", 0, 1);
    step(mk(6'h00, 5'd0, 5'd6, 16'h0800), mk(6'h23, 5'd1, 5'd0, 16'h0), 1, "R4 r0 source", 0, 1);
    step(mk(6'h00, 5'd3, 5'd3, 16'h0800), ld3, 0, "R5 invalid slot", 0, 1);
    step(mk(6'h00, 5'd3, 5'd3, 16'h0800), mk(6'h00, 5'd1, 5'd3, 16'h1800), 1, "R5 alu producer", 0, 1);
    step(mk(6'h00, 5'd3, 5'd3, 16'h0800), mk(6'h08, 5'd1, 5'd3, 16'h0001), 1, "R5 imm producer", 0, 1);
    step(mk(6'h02, 5'd3, 5'd3, 16'h0000), ld3, 1, "R8 jump", 0, 1);
    step(mk(6'h3F, 5'd3, 5'd3, 16'h0000), ld3, 1, "R8 unlisted opcode", 0, 1);
    // held hazard with both fields matching: stall, release, stall
    step(mk(6'h00, 5'd3, 5'd3, 16'h0800), ld3, 1, "R6 both fields first", 1, 1);
    step(mk(6'h00, 5'd3, 5'd3, 16'h0800), ld3, 1, "R6 held second", 0, 1);
    step(mk(6'h00, 5'd3, 5'd3, 16'h0800), ld3, 1, "R6 held third", 1, 1);
    step(alu3, ld3, 1, "R6 after stall unrelated", 0, 1);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] c, p;
      c = mk(ops[$urandom % 7], 5'($urandom % 4), 5'($urandom % 4), 16'($urandom));
      p = mk(($urandom % 3 != 0) ? 6'h23 : ops[$urandom % 7],
             5'($urandom % 4), 5'($urandom % 4), 16'($urandom));
      step(c, p, ($urandom % 5) != 0, "R1 R2 R6 random", 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule